// File: doc/BRIEF.md
# Integer Element Broadcast Unit

This pipelined SIMD stage takes the lowest element of a 64-bit source value and writes a copy of it into every element lane of a vector result. The element size can be byte, word, dword or qword. The vector length can be 128 or 256 bits. In 128-bit form only the lower half of the result carries copies, and the upper half is forced to zero.

The issue logic presents one operation per cycle with a valid strobe and its encoding fields. The unit checks the W bit and the 4-bit vvvv register-specifier field. An operation whose encoding is illegal raises an undefined-opcode fault instead of producing a result. Loading the source from memory and the rest of opcode decode are done elsewhere.

Top module: `bcast_unit`

## Requirements
- R1: With `size_i` = 2'b00 (byte), source bits 7:0 fill 16 byte lanes when `len256_i` = 0 and 32 byte lanes when `len256_i` = 1.
- R2: With `size_i` = 2'b01 (word), source bits 15:0 fill 8 word lanes when `len256_i` = 0 and 16 word lanes when `len256_i` = 1.
- R3: With `size_i` = 2'b10 (dword), source bits 31:0 fill 4 dword lanes when `len256_i` = 0 and 8 dword lanes when `len256_i` = 1.
- R4: With `size_i` = 2'b11 (qword), source bits 63:0 fill 2 qword lanes when `len256_i` = 0 and 4 qword lanes when `len256_i` = 1.
- R5: When `len256_i` = 0, `result_o[255:128]` is zero for every element size.
- R6: A valid operation with `vvvv_i` other than 4'b1111 sets `fault_o` and does not set `valid_o`.
- R7: A valid operation with `w_i` = 1 sets `fault_o` and does not set `valid_o`, for every element size.
- R8: Source bits above the selected element width have no effect on `result_o`.
- R9: Result, valid and fault appear exactly one cycle after the input. `valid_o` is high only for a valid operation that does not fault, and both flags are low after a cycle with `valid_i` = 0.
- R10: Reset clears `result_o`, `valid_o` and `fault_o`.
- R11: `result_o` keeps its value after an idle cycle and after a faulting operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| size_i | input | 2 | Element size: 00 byte, 01 word, 10 dword, 11 qword |
| len256_i | input | 1 | 1 selects a 256-bit vector, 0 selects 128-bit |
| w_i | input | 1 | W encoding bit; must be 0 |
| vvvv_i | input | 4 | Register-specifier field; must be 4'b1111 |
| src_i | input | 64 | Source value; the low element is broadcast |
| result_o | output | 256 | Registered broadcast result |
| valid_o | output | 1 | Result valid, one cycle after an accepted operation |
| fault_o | output | 1 | Undefined-opcode fault, one cycle after an illegal operation |

## Verification
Every output is due in the first cycle after the edge that captures the stimulus. The bench drives inputs on the falling edge. It samples `result_o`, `valid_o` and `fault_o` on the next falling edge, which falls after exactly one rising edge. It then drops `valid_i` and samples one more falling edge later, to confirm that the flags clear and the result holds. Expected lanes are computed bit by bit from the element width and the vector length.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
  localparam int unsigned SRC_W  = 64;
  localparam int unsigned VEC_W  = 256;
  localparam int unsigned HALF_W = VEC_W / 2;
  localparam int unsigned N_SIZE = 4;

  typedef enum logic [1:0] {
    ESZ_BYTE  = 2'b00,
    ESZ_WORD  = 2'b01,
    ESZ_DWORD = 2'b10,
    ESZ_QWORD = 2'b11
  } elem_size_e;
endpackage

// File: rtl/bcast_legal.sv
module bcast_legal #(
  parameter int unsigned FIELD_W = 4
) (
  input  logic               w_i,
  input  logic [FIELD_W-1:0] vvvv_i,
  output logic               illegal_o
);
  // Specifier field must be all ones, W must be zero.
  assign illegal_o = w_i | ~(&vvvv_i);
endmodule

// File: rtl/bcast_replicate.sv
module bcast_replicate
  import bcast_pkg::*;
#(
  parameter int unsigned S_W = SRC_W,
  parameter int unsigned V_W = VEC_W
) (
  input  logic [1:0]     size_i,
  input  logic           len256_i,
  input  logic [S_W-1:0] src_i,
  output logic [V_W-1:0] vec_o
);
  localparam int unsigned H_W = V_W / 2;

  logic [V_W-1:0] rep [N_SIZE];
  logic [V_W-1:0] sel;

  for (genvar sz = 0; sz < N_SIZE; sz++) begin : g_size
    localparam int unsigned EW = 8 << sz;
    localparam int unsigned NL = V_W / EW;
    assign rep[sz] = {NL{src_i[EW-1:0]}};
  end

  always_comb begin
    unique case (elem_size_e'(size_i))
      ESZ_BYTE:  sel = rep[0];
      ESZ_WORD:  sel = rep[1];
      ESZ_DWORD: sel = rep[2];
      default:   sel = rep[3];
    endcase
  end

  assign vec_o = len256_i ? sel : {{H_W{1'b0}}, sel[H_W-1:0]};
endmodule

// File: rtl/bcast_unit.sv
module bcast_unit
  import bcast_pkg::*;
#(
  parameter int unsigned S_W = SRC_W,
  parameter int unsigned V_W = VEC_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [1:0]     size_i,
  input  logic           len256_i,
  input  logic           w_i,
  input  logic [3:0]     vvvv_i,
  input  logic [S_W-1:0] src_i,
  output logic [V_W-1:0] result_o,
  output logic           valid_o,
  output logic           fault_o
);
  localparam int unsigned H_W = V_W / 2;

  logic           illegal;
  logic [V_W-1:0] vec_d;
  logic           accept;

  bcast_legal #(.FIELD_W(4)) u_legal (
    .w_i      (w_i),
    .vvvv_i   (vvvv_i),
    .illegal_o(illegal)
  );

  bcast_replicate #(.S_W(S_W), .V_W(V_W)) u_rep (
    .size_i  (size_i),
    .len256_i(len256_i),
    .src_i   (src_i),
    .vec_o   (vec_d)
  );

  assign accept = valid_i & ~illegal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
      fault_o  <= 1'b0;
    end else begin
      valid_o <= accept;
      fault_o <= valid_i & illegal;
      if (accept) result_o <= vec_d;
    end
  end

  p_w_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && w_i |=> fault_o && !valid_o);
  p_vvvv_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (vvvv_i != 4'hF) |=> fault_o && !valid_o);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !fault_o);
  p_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({valid_o, fault_o}));
  p_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !len256_i && !w_i && (vvvv_i == 4'hF) |=> result_o[V_W-1:H_W] == '0);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i || w_i || (vvvv_i != 4'hF) |=> $stable(result_o));
endmodule

// File: tb/bcast_unit_tb.sv
module bcast_unit_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         valid_i;
  logic [1:0]   size_i;
  logic         len256_i;
  logic         w_i;
  logic [3:0]   vvvv_i;
  logic [63:0]  src_i;
  logic [255:0] result_o;
  logic         valid_o;
  logic         fault_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  bcast_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .size_i(size_i),
    .len256_i(len256_i), .w_i(w_i), .vvvv_i(vvvv_i), .src_i(src_i),
    .result_o(result_o), .valid_o(valid_o), .fault_o(fault_o)
  );

  function automatic logic [255:0] expect_vec(input logic [1:0] sz, input logic l256,
                                              input logic [63:0] s);
    int ew  = 8 << sz;
    int lim = l256 ? 256 : 128;
    logic [255:0] r = '0;
    for (int b = 0; b < lim; b++) r[b] = s[b % ew];
    return r;
  endfunction

  task automatic chk_vec(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: result actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Drive on falling edge, sample one falling edge later (one rising edge between).
  task automatic issue(input logic [1:0] sz, input logic l256, input logic w,
                       input logic [3:0] vv, input logic [63:0] s);
    @(negedge clk_i);
    valid_i = 1'b1; size_i = sz; len256_i = l256; w_i = w; vvvv_i = vv; src_i = s;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  function automatic string req_of(input logic [1:0] sz);
    case (sz)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    logic [63:0] pats [6];
    logic [255:0] prev;
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h8000_0000_0000_0001;
    pats[3] = 64'hDEAD_BEEF_CAFE_F00D;
    pats[4] = 64'h0000_0000_0000_0000;
    pats[5] = 64'h5A5A_A5A5_3C3C_C3C3;

    rst_ni = 1'b0; valid_i = 1'b0; size_i = '0; len256_i = 1'b0;
    w_i = 1'b0; vvvv_i = 4'hF; src_i = '0;
    repeat (3) @(negedge clk_i);
    chk_vec("R10", result_o, '0);
    chk_bit("R10", "valid", valid_o, 1'b0);
    chk_bit("R10", "fault", fault_o, 1'b0);
    rst_ni = 1'b1;

    // Sweep sizes, lengths and source patterns.
    for (int sz = 0; sz < 4; sz++) begin
      for (int l = 0; l < 2; l++) begin
        for (int p = 0; p < 6; p++) begin
          issue(2'(sz), 1'(l), 1'b0, 4'hF, pats[p]);
          chk_vec(req_of(2'(sz)), result_o, expect_vec(2'(sz), 1'(l), pats[p]));
          chk_bit("R9", "valid", valid_o, 1'b1);
          chk_bit("R9", "fault", fault_o, 1'b0);
          if (l == 0) chk_vec("R5", {128'h0, 128'h0} | (result_o & {128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'h0}), '0);
          @(negedge clk_i);
          chk_bit("R9", "valid idle", valid_o, 1'b0);
          chk_vec("R11", result_o, expect_vec(2'(sz), 1'(l), pats[p]));
        end
      end
    end

    // Upper source bits ignored: R8.
    for (int sz = 0; sz < 3; sz++) begin
      issue(2'(sz), 1'b1, 1'b0, 4'hF, 64'h0000_0000_0000_00A7);
      prev = result_o;
      issue(2'(sz), 1'b1, 1'b0, 4'hF,
            64'h0000_0000_0000_00A7 | (64'hFFFF_FFFF_FFFF_FFFF << (8 << sz)));
      chk_vec("R8", result_o, prev);
    end

    // Fault sweep over vvvv and W: R6, R7, R11.
    issue(2'd2, 1'b1, 1'b0, 4'hF, 64'h1111_2222_3333_4444);
    prev = result_o;
    for (int sz = 0; sz < 4; sz++) begin
      for (int w = 0; w < 2; w++) begin
        for (int v = 0; v < 16; v++) begin
          if (w == 0 && v == 15) continue;
          issue(2'(sz), 1'b1, 1'(w), 4'(v), 64'hFEDC_BA98_7654_3210);
          chk_bit(w ? "R7" : "R6", "fault", fault_o, 1'b1);
          chk_bit(w ? "R7" : "R6", "valid", valid_o, 1'b0);
          chk_vec("R11", result_o, prev);
        end
      end
    end
    @(negedge clk_i);
    chk_bit("R9", "fault idle", fault_o, 1'b0);

    // Reset in mid-stream: R10.
    issue(2'd0, 1'b1, 1'b0, 4'hF, 64'hFF);
    rst_ni = 1'b0;
    #1;
    chk_vec("R10", result_o, '0);
    chk_bit("R10", "valid", valid_o, 1'b0);
    rst_ni = 1'b1;

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9: watchdog actual %0d cycles expected completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule